// File: doc/BRIEF.md
# Oversampling UART Receiver with Error Flags

This block recovers bytes from an asynchronous serial line. The block receives a
one-cycle enable that pulses at sixteen times the bit rate. The receive line passes
through a synchronizer and goes to a frame engine. The frame engine finds a start bit
and samples every bit near its centre. It shifts the data in least significant bit
first, then takes an optional parity bit and one or two stop bits. When the first stop
bit has been sampled, the assembled byte moves into a single receive buffer and the
ready flag rises.

Three sticky error flags describe the quality of the stream. The overrun flag marks a
byte that arrived while the previous byte was still unread. The framing flag marks a
stop bit that was sampled low. The parity flag marks a parity mismatch. None of these
errors stops reception or discards a byte. Software reads the buffer through a read
strobe. It clears the framing and parity flags by writing ones. Only a module soft
reset clears the overrun flag.

Top module: `uart_rx_err`

## Requirements
- R1: After `rst_n` is low, or in the cycle after a one-cycle `soft_rst` pulse, `rx_ready`, `err_ovr`, `err_frm` and `err_par` are all 0, and the frame engine is idle.
- R2: A frame is one low start bit, `DATA_W` data bits sent least significant bit first, a parity bit only when `cfg_par_en` is 1, and one stop bit, or two stop bits when `cfg_two_stop` is 1. Each bit lasts `OSR` tick pulses. When the first stop bit is sampled, the data goes to `rd_data` and `rx_ready` becomes 1.
- R3: A start bit begins only on a high-to-low transition of the synchronized line. The line must still be low when sampled `OSR/2` ticks later. A shorter low pulse returns the engine to idle, and no byte is delivered.
- R4: A `rd_stb` pulse clears `rx_ready` at the next clock edge. `rd_data` keeps its value.
- R5: If a frame completes while `rx_ready` is 1 and no `rd_stb` occurs in that cycle, `err_ovr` becomes 1. The new byte replaces the buffer contents.
- R6: Writes do not clear `err_ovr`. Only `soft_rst` or `rst_n` clear it.
- R7: A first stop bit sampled as 0 sets `err_frm`. The byte is still stored, and `rx_ready` is still set.
- R8: With two stop bits configured, the second stop bit is not checked. A low second stop bit leaves `err_frm` at 0.
- R9: With parity enabled, the received bit is compared with the configured parity. With `cfg_par_odd`=0 (even), data plus parity must hold an even number of ones. With `cfg_par_odd`=1 (odd), they must hold an odd number. A mismatch sets `err_par`, and the byte is still stored. With parity disabled, `err_par` never sets.
- R10: A `wr_stb` pulse with `wr_clr_frm`=1 clears `err_frm`. A `wr_stb` pulse with `wr_clr_par`=1 clears `err_par`. Each bit clears only its own flag, and a new error in the same cycle wins over the clear.
- R11: After any error, the following frames are received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous module reset pulse |
| tick | input | 1 | Oversampling enable, OSR pulses per bit |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_par_en | input | 1 | Expect a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Frame carries two stop bits |
| rd_stb | input | 1 | Read strobe for the receive buffer |
| wr_stb | input | 1 | Flag-clear write strobe |
| wr_clr_frm | input | 1 | Write-1 clear of the framing flag |
| wr_clr_par | input | 1 | Write-1 clear of the parity flag |
| rd_data | output | DATA_W | Receive buffer |
| rx_ready | output | 1 | Buffer holds an unread byte |
| err_ovr | output | 1 | Overrun flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |

## Verification
The assertions assume that the configuration inputs stay stable while a frame is in flight. They also assume that `soft_rst` is a pulse, and that the read and clear strobes last one cycle. The bench drives the configuration only between frames and then waits for the line to go idle. It drives each strobe for exactly one cycle, on the falling clock edge. It holds `tick` high, so every bit lasts exactly `OSR` cycles. The sampling point therefore stays well inside each bit, even after the synchronizer delay.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4,
        RX_STOP2 = 3'd5
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              rx,
    input  logic              cfg_par_en,
    input  logic              cfg_two_stop,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_bit,
    output logic              stop_ok
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] TOP_C  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              stop_ok;
        logic              prev;
        logic              done;
    } fr_t;

    localparam fr_t FR_RST = '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0,
                               par: 1'b0, stop_ok: 1'b1, prev: 1'b1, done: 1'b0};

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        if (tick) begin
            fr_d.prev = rx;
            unique case (fr_q.st)
                RX_IDLE: begin
                    if (fr_q.prev && !rx) begin
                        fr_d.st  = RX_START;
                        fr_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (fr_q.cnt == MID_C) begin
                        fr_d.cnt = '0;
                        fr_d.idx = '0;
                        fr_d.st  = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (fr_q.cnt == LAST_C) begin
                        fr_d.cnt = '0;
                        if (DATA_W > 1) fr_d.sh = {rx, fr_q.sh[DATA_W-1:1]};
                        else            fr_d.sh = rx;
                        if (fr_q.idx == TOP_C) fr_d.st = cfg_par_en ? RX_PAR : RX_STOP;
                        else                   fr_d.idx = fr_q.idx + 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (fr_q.cnt == LAST_C) begin
                        fr_d.cnt = '0;
                        fr_d.par = rx;
                        fr_d.st  = RX_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (fr_q.cnt == LAST_C) begin
                        fr_d.cnt     = '0;
                        fr_d.stop_ok = rx;
                        fr_d.done    = 1'b1;
                        fr_d.st      = cfg_two_stop ? RX_STOP2 : RX_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_STOP2: begin
                    if (fr_q.cnt == LAST_C) begin
                        fr_d.cnt = '0;
                        fr_d.st  = RX_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: fr_d = FR_RST;
            endcase
        end
        if (soft_rst) fr_d = FR_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= FR_RST;
        else        fr_q <= fr_d;
    end

    assign done    = fr_q.done;
    assign data    = fr_q.sh;
    assign par_bit = fr_q.par;
    assign stop_ok = fr_q.stop_ok;

    // R3: a line that is high again at the mid-start sample aborts the frame
    p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == RX_START && tick && fr_q.cnt == MID_C && rx && !soft_rst)
        |=> (fr_q.st == RX_IDLE));

    // R2: completion is only reported straight after the stop state
    p_done_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.done |-> ($past(fr_q.st) == RX_STOP));

    // R1: soft reset returns the engine to idle
    p_soft_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (fr_q.st == RX_IDLE && !fr_q.done));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              stop_ok,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              wr_clr_frm,
    input  logic              wr_clr_par,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              ovr,
    output logic              frm,
    output logic              par
);
    typedef struct packed {
        logic [DATA_W-1:0] buf_v;
        logic              ready;
        logic              ovr;
        logic              frm;
        logic              par;
    } fl_t;

    localparam fl_t FL_RST = '{buf_v: '0, ready: 1'b0, ovr: 1'b0, frm: 1'b0, par: 1'b0};

    fl_t  fl_d, fl_q;
    logic par_bad;

    always_comb par_bad = cfg_par_en & ((^data) ^ par_bit ^ cfg_par_odd);

    always_comb begin
        fl_d = fl_q;
        if (rd_stb) fl_d.ready = 1'b0;
        if (wr_stb) begin
            if (wr_clr_frm) fl_d.frm = 1'b0;
            if (wr_clr_par) fl_d.par = 1'b0;
        end
        if (done) begin
            fl_d.buf_v = data;
            fl_d.ready = 1'b1;
            if (fl_q.ready && !rd_stb) fl_d.ovr = 1'b1;
            if (!stop_ok)              fl_d.frm = 1'b1;
            if (par_bad)               fl_d.par = 1'b1;
        end
        if (soft_rst) fl_d = FL_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= FL_RST;
        else        fl_q <= fl_d;
    end

    assign rd_data = fl_q.buf_v;
    assign ready   = fl_q.ready;
    assign ovr     = fl_q.ovr;
    assign frm     = fl_q.frm;
    assign par     = fl_q.par;

    p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!fl_q.ready && !fl_q.ovr && !fl_q.frm && !fl_q.par));

    p_ready_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst) |=> (fl_q.ready && fl_q.buf_v == $past(data)));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done && !soft_rst) |=> (!fl_q.ready && $stable(fl_q.buf_v)));

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fl_q.ready && !rd_stb && !soft_rst) |=> fl_q.ovr);

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ovr && !soft_rst) |=> fl_q.ovr);

    p_frm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !stop_ok && !soft_rst) |=> fl_q.frm);

    p_par_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_par_en && !fl_q.par && !soft_rst) |=> !fl_q.par);

    p_w1c_par_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_clr_par && !done && !soft_rst) |=> !fl_q.par);
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              rx_in,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              wr_clr_frm,
    input  logic              wr_clr_par,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              err_par
);
    logic              rx_s;
    logic              f_done;
    logic [DATA_W-1:0] f_data;
    logic              f_par;
    logic              f_stop_ok;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .tick        (tick),
        .rx          (rx_s),
        .cfg_par_en  (cfg_par_en),
        .cfg_two_stop(cfg_two_stop),
        .done        (f_done),
        .data        (f_data),
        .par_bit     (f_par),
        .stop_ok     (f_stop_ok)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .done       (f_done),
        .data       (f_data),
        .par_bit    (f_par),
        .stop_ok    (f_stop_ok),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_clr_frm (wr_clr_frm),
        .wr_clr_par (wr_clr_par),
        .rd_data    (rd_data),
        .ready      (rx_ready),
        .ovr        (err_ovr),
        .frm        (err_frm),
        .par        (err_par)
    );
endmodule

// File: tb/test_uart_rx_err.sv
module test_uart_rx_err;
    localparam int DW  = 8;
    localparam int OSR = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, tick = 1'b1, rx_in = 1'b1;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic rd_stb = 1'b0, wr_stb = 1'b0, wr_clr_frm = 1'b0, wr_clr_par = 1'b0;
    logic [DW-1:0] rd_data;
    logic rx_ready, err_ovr, err_frm, err_par;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_err #(.DATA_W(DW), .OSR(OSR)) i_uart_rx_err (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick), .rx_in(rx_in),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_clr_frm(wr_clr_frm), .wr_clr_par(wr_clr_par),
        .rd_data(rd_data), .rx_ready(rx_ready), .err_ovr(err_ovr),
        .err_frm(err_frm), .err_par(err_par)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        rx_in = v;
        repeat (OSR) @(negedge clk);
    endtask

    task automatic send(input logic [DW-1:0] d, input bit bad_par,
                        input bit stop0, input bit stop2_0);
        line_bit(1'b0);
        for (int i = 0; i < DW; i++) line_bit(d[i]);
        if (cfg_par_en) line_bit((cfg_par_odd ? ~^d : ^d) ^ bad_par);
        line_bit(!stop0);
        if (cfg_two_stop) line_bit(!stop2_0);
        rx_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_clear(input bit f, input bit p);
        wr_stb = 1'b1; wr_clr_frm = f; wr_clr_par = p;
        @(negedge clk);
        wr_stb = 1'b0; wr_clr_frm = 1'b0; wr_clr_par = 1'b0;
    endtask

    task automatic do_soft();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset ready", rx_ready, 0);
        chk("R1 reset ovr", err_ovr, 0);
        chk("R1 reset frm", err_frm, 0);
        chk("R1 reset par", err_par, 0);

        // R2 R9 R4 R10: every byte value, even parity, some parity bits corrupted
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        for (int v = 0; v < 256; v++) begin
            bit bad = (v % 5 == 0);
            send(DW'(v), bad, 1'b0, 1'b0);
            chk("R2 sweep data", rd_data, v);
            chk("R2 sweep ready", rx_ready, 1);
            chk("R9 sweep parity flag", err_par, bad);
            chk("R7 sweep frm", err_frm, 0);
            do_read();
            chk("R4 read clears ready", rx_ready, 0);
            chk("R4 data kept", rd_data, v);
            do_clear(1'b1, 1'b1);
            chk("R10 par cleared", err_par, 0);
        end

        // R2 R7 R8 R9: all configurations, mixed errors
        for (int c = 0; c < 8; c++) begin
            cfg_par_en = c[0]; cfg_par_odd = c[1]; cfg_two_stop = c[2];
            repeat (4) @(negedge clk);
            for (int k = 0; k < 6; k++) begin
                logic [DW-1:0] d = DW'((c * 37 + k * 91 + 5) & 8'hff);
                bit bad = (k % 3 == 1);
                bit s0  = (k == 2);
                bit s20 = (k == 4);
                send(d, bad, s0, s20);
                chk("R2 cfg data", rd_data, d);
                chk("R7 R8 cfg frm", err_frm, s0);
                chk("R9 cfg par", err_par, cfg_par_en && bad);
                chk("R5 cfg no ovr", err_ovr, 0);
                do_read();
                do_clear(1'b1, 1'b1);
            end
        end

        // R5 R6 R11 R1: overrun, sticky flag, continued reception, soft reset
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        send(8'hA5, 1'b0, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 1'b0, 1'b0);
        chk("R5 ovr set", err_ovr, 1);
        chk("R5 new byte overwrites", rd_data, 8'h3C);
        do_clear(1'b1, 1'b1);
        chk("R6 ovr not cleared by write", err_ovr, 1);
        do_read();
        send(8'h5E, 1'b0, 1'b0, 1'b0);
        chk("R11 after ovr data", rd_data, 8'h5E);
        chk("R11 after ovr ready", rx_ready, 1);
        chk("R6 ovr still set", err_ovr, 1);
        do_soft();
        chk("R6 ovr cleared by soft reset", err_ovr, 0);
        chk("R1 soft reset ready", rx_ready, 0);

        // R3: short low glitch is rejected
        rx_in = 1'b0;
        repeat (5) @(negedge clk);
        rx_in = 1'b1;
        repeat (12 * OSR) @(negedge clk);
        chk("R3 glitch no byte", rx_ready, 0);
        send(8'h81, 1'b0, 1'b0, 1'b0);
        chk("R3 frame after glitch", rd_data, 8'h81);
        do_read();

        // R10 R11: selective clear, then a clean frame
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        send(8'h0F, 1'b1, 1'b1, 1'b0);
        chk("R7 frm set", err_frm, 1);
        chk("R9 odd par bad", err_par, 1);
        chk("R7 byte stored", rd_data, 8'h0F);
        do_clear(1'b1, 1'b0);
        chk("R10 frm cleared", err_frm, 0);
        chk("R10 par kept", err_par, 1);
        do_clear(1'b0, 1'b1);
        chk("R10 par cleared", err_par, 0);
        do_read();
        send(8'hC3, 1'b0, 1'b0, 1'b0);
        chk("R11 clean after errors data", rd_data, 8'hC3);
        chk("R11 clean frm", err_frm, 0);
        chk("R11 clean par", err_par, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule